// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit gathers the twelve event sources of an I2C controller into one raw status vector. A writable mask selects which events drive the single interrupt line. Software reads a masked view of the status, and clears events through read-to-clear addresses. There is one clear address per clearable event and one address that clears all of them at once. Because each event has its own clear address, an event that fires between a status read and the matching clear is not lost.

Two of the events are levels that follow FIFO conditions: receive-above-threshold and transmit-below-threshold. They mirror their inputs and cannot be cleared. A separate abort-source register collects the cause bits of an aborted transfer. It is cleared only by a read of the transmit-abort clear address.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, the raw status, the abort source, the interrupt output and the read data are all zero.
- R2: The mask register resets to 0x254, which enables bits 2, 4, 6 and 9.
- R3: An edge-type event pulse on `evt_pulse[i]` sets raw status bit i at the next clock edge. The bit order is: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop detected, 10 start detected, 11 general call. A raw bit never rises without its event.
- R4: Address 1 reads the raw status ANDed with the mask. Address 0 reads the raw status.
- R5: A write to address 2 loads the mask from `reg_wdata`. Reads of address 2 return the mask. Writes to any other address are ignored.
- R6: A read of address 8+i returns raw bit i in bit 0 and clears only that bit.
- R7: A read of address 4 clears every clearable raw bit at once and returns zero.
- R8: Raw bits 2 and 4 follow `rx_full_lvl` and `tx_empty_lvl` with one cycle of delay. No clear read affects them.
- R9: If an event pulse arrives in the same cycle as a clear read of its bit, the bit stays set.
- R10: Address 3 reads the abort source. Each cause bit on `abort_cause` sets its bit and stays set. Cause bits 6 and 8 are reserved and always read zero. The valid positions are: 0 7-bit address NACK, 1 first 10-bit address byte NACK, 2 second 10-bit address byte NACK, 3 data NACK, 4 general-call NACK, 5 read after general call, 7 start byte acknowledged, 9 start byte with restart off, 10 10-bit read with restart off, 11 use while disabled, 12 arbitration lost.
- R11: The abort source is cleared only by a read of address 14, the tx-abort clear. A global clear read leaves it unchanged.
- R12: `irq` is the OR of the masked status bits, registered, so it follows the raw status and the mask one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 12 | One-cycle event pulses from the controller |
| rx_full_lvl | input | 1 | Receive-threshold level condition |
| tx_empty_lvl | input | 1 | Transmit-threshold level condition |
| abort_cause | input | 13 | Abort cause bits to accumulate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 12 | Write data, used for the mask |
| reg_rdata | output | 16 | Read data, valid in the cycle after the read strobe |
| irq | output | 1 | Interrupt line |

## Verification
The bench fires an event in the same cycle as the clear read of that event. A design where the clear wins would lose the interrupt and read the bit as zero. It issues global and per-bit clears against the level bits and the abort source. A design that cleared these would show RX_FULL or TX_EMPTY dropping, or the abort causes vanishing after a global clear. It also drives the reserved abort cause positions, writes to the read-only masked-status address, and checks that `irq` follows mask changes, so decode slips or a combinational or missing interrupt stage show up as wrong values.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NUM_EVT    = 12;
    localparam int ABRT_W     = 13;
    localparam int ADDR_W     = 6;
    localparam int RD_W       = 16;

    localparam int EV_RX_FULL  = 2;
    localparam int EV_TX_EMPTY = 4;
    localparam int EV_TX_ABRT  = 6;

    localparam logic [NUM_EVT-1:0] LEVEL_EVENTS = NUM_EVT'((1 << EV_RX_FULL) | (1 << EV_TX_EMPTY));
    localparam logic [NUM_EVT-1:0] DEFAULT_MASK = 12'h254;
    localparam logic [ABRT_W-1:0]  ABRT_VALID   = 13'h1EBF;

    localparam int A_RAW      = 0;
    localparam int A_MASKED   = 1;
    localparam int A_MASK     = 2;
    localparam int A_ABRT     = 3;
    localparam int A_CLR_ALL  = 4;
    localparam int A_CLR_BASE = 8;

    typedef struct packed {
        logic [NUM_EVT-1:0] raw;
        logic [NUM_EVT-1:0] mask;
        logic [ABRT_W-1:0]  abrt;
        logic               irq;
    } isu_state_t;
endpackage

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
    import i2c_irq_pkg::*;
(
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [NUM_EVT-1:0] clr_vec,
    output logic              clr_abrt,
    output logic              mask_we
);
    logic hit_all;
    assign hit_all  = reg_rd && (reg_addr == ADDR_W'(A_CLR_ALL));
    assign clr_abrt = reg_rd && (reg_addr == ADDR_W'(A_CLR_BASE + EV_TX_ABRT));
    assign mask_we  = reg_wr && (reg_addr == ADDR_W'(A_MASK));

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
        if (LEVEL_EVENTS[i]) begin : g_level
            assign clr_vec[i] = 1'b0;
        end else begin : g_edge
            assign clr_vec[i] = hit_all ||
                (reg_rd && (reg_addr == ADDR_W'(A_CLR_BASE + i)));
        end
    end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import i2c_irq_pkg::*;
#(
    parameter logic [NUM_EVT-1:0] MASK_RESET = DEFAULT_MASK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               rx_full_lvl,
    input  logic               tx_empty_lvl,
    input  logic [ABRT_W-1:0]  abort_cause,
    input  logic [NUM_EVT-1:0] clr_vec,
    input  logic               clr_abrt,
    input  logic               mask_we,
    input  logic [NUM_EVT-1:0] mask_wdata,
    output logic [NUM_EVT-1:0] raw,
    output logic [NUM_EVT-1:0] mask,
    output logic [ABRT_W-1:0]  abrt,
    output logic               irq
);
    isu_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // pending event beats a clear in the same cycle
        st_d.raw = (st_q.raw & ~clr_vec) | (evt_pulse & ~LEVEL_EVENTS);
        st_d.raw[EV_RX_FULL]  = rx_full_lvl;
        st_d.raw[EV_TX_EMPTY] = tx_empty_lvl;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        st_d.abrt = (clr_abrt ? '0 : st_q.abrt) | (abort_cause & ABRT_VALID);
        st_d.irq  = |(st_q.raw & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= MASK_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw  = st_q.raw;
    assign mask = st_q.mask;
    assign abrt = st_q.abrt;
    assign irq  = st_q.irq;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import i2c_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_EVT-1:0] raw,
    input  logic [NUM_EVT-1:0] mask,
    input  logic [ABRT_W-1:0]  abrt,
    output logic [RD_W-1:0]    rdata
);
    logic [RD_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (reg_rd) begin
            if (reg_addr == ADDR_W'(A_RAW))    rdata_d = RD_W'(raw);
            if (reg_addr == ADDR_W'(A_MASKED)) rdata_d = RD_W'(raw & mask);
            if (reg_addr == ADDR_W'(A_MASK))   rdata_d = RD_W'(mask);
            if (reg_addr == ADDR_W'(A_ABRT))   rdata_d = RD_W'(abrt);
            for (int i = 0; i < NUM_EVT; i++) begin
                if (reg_addr == ADDR_W'(A_CLR_BASE + i)) rdata_d = RD_W'(raw[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter logic [NUM_EVT-1:0] MASK_RESET = DEFAULT_MASK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               rx_full_lvl,
    input  logic               tx_empty_lvl,
    input  logic [ABRT_W-1:0]  abort_cause,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_EVT-1:0] reg_wdata,
    output logic [RD_W-1:0]    reg_rdata,
    output logic               irq
);
    logic [NUM_EVT-1:0] clr_vec, raw_w, mask_w;
    logic [ABRT_W-1:0]  abrt_w;
    logic               clr_abrt, mask_we;

    irq_clr_decode u_dec (
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .clr_vec(clr_vec), .clr_abrt(clr_abrt), .mask_we(mask_we)
    );

    irq_status_regs #(.MASK_RESET(MASK_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .rx_full_lvl(rx_full_lvl), .tx_empty_lvl(tx_empty_lvl),
        .abort_cause(abort_cause), .clr_vec(clr_vec), .clr_abrt(clr_abrt),
        .mask_we(mask_we), .mask_wdata(reg_wdata),
        .raw(raw_w), .mask(mask_w), .abrt(abrt_w), .irq(irq)
    );

    irq_read_mux u_rd (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .raw(raw_w), .mask(mask_w), .abrt(abrt_w), .rdata(reg_rdata)
    );
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk
    import i2c_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               rx_full_lvl,
    input logic [ABRT_W-1:0]  abort_cause,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_EVT-1:0] raw,
    input logic [ABRT_W-1:0]  abrt
);
    logic [NUM_EVT-1:0] clr_hit;
    logic [NUM_EVT-1:0] edge_evt;

    always_comb begin
        for (int i = 0; i < NUM_EVT; i++) begin
            clr_hit[i] = !LEVEL_EVENTS[i] && reg_rd &&
                ((reg_addr == ADDR_W'(A_CLR_BASE + i)) || (reg_addr == ADDR_W'(A_CLR_ALL)));
        end
    end
    assign edge_evt = evt_pulse & ~LEVEL_EVENTS;

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_evt) |=> ((raw & $past(edge_evt)) == $past(edge_evt)));

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & ~$past(raw) & ~LEVEL_EVENTS & ~$past(evt_pulse)) == '0));

    assert_clear_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_hit & ~evt_pulse)) |=> ((raw & $past(clr_hit & ~evt_pulse)) == '0));

    assert_level_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (raw[EV_RX_FULL] == $past(rx_full_lvl)));

    assert_abort_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (abrt & ~ABRT_VALID) == '0);

    assert_abort_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_cause == '0 && !(reg_rd && reg_addr == ADDR_W'(A_CLR_BASE + EV_TX_ABRT)))
        |=> $stable(abrt));
endmodule

bind i2c_irq_status i2c_irq_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rx_full_lvl(rx_full_lvl),
    .abort_cause(abort_cause), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .raw(raw_w), .abrt(abrt_w)
);

// File: tb/i2c_irq_status_test.sv
module i2c_irq_status_test;
    import i2c_irq_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt_pulse = '0;
    logic               rx_full_lvl = 1'b0, tx_empty_lvl = 1'b0;
    logic [ABRT_W-1:0]  abort_cause = '0;
    logic               reg_wr = 1'b0, reg_rd = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [NUM_EVT-1:0] reg_wdata = '0;
    logic [RD_W-1:0]    reg_rdata;
    logic               irq;
    int n_chk = 0, n_bad = 0;

    i2c_irq_status uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rd(int addr, logic [NUM_EVT-1:0] ev, output logic [RD_W-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ADDR_W'(addr); evt_pulse = ev;
        @(negedge clk);
        reg_rd = 1'b0; evt_pulse = '0;
        d = reg_rdata;
    endtask

    task automatic wr(int addr, logic [NUM_EVT-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(logic [NUM_EVT-1:0] ev, logic [ABRT_W-1:0] ab);
        @(negedge clk);
        evt_pulse = ev; abort_cause = ab;
        @(negedge clk);
        evt_pulse = '0; abort_cause = '0;
    endtask

    task automatic t_reset();
        logic [RD_W-1:0] d;
        check("R1", "irq after reset", 32'(irq), 0);
        check("R1", "rdata after reset", 32'(reg_rdata), 0);
        rd(A_RAW, '0, d);  check("R1", "raw", 32'(d), 0);
        rd(A_ABRT, '0, d); check("R1", "abort src", 32'(d), 0);
        rd(A_MASK, '0, d); check("R2", "mask default", 32'(d), 32'h254);
    endtask

    task automatic t_events();
        logic [RD_W-1:0] d;
        pulse(12'h201, '0);
        rd(A_RAW, '0, d);    check("R3", "raw after pulses", 32'(d), 32'h201);
        rd(A_MASKED, '0, d); check("R4", "masked status", 32'(d), 32'h200);
        check("R12", "irq with masked bit", 32'(irq), 1);
        rd(A_CLR_BASE + 0, '0, d); check("R6", "clear read value", 32'(d), 1);
        rd(A_RAW, '0, d);    check("R6", "only bit0 cleared", 32'(d), 32'h200);
        rd(A_CLR_BASE + 0, '0, d); check("R6", "second clear read", 32'(d), 0);
    endtask

    task automatic t_global();
        logic [RD_W-1:0] d;
        pulse(12'hFEB, '0);
        rd(A_RAW, '0, d);      check("R3", "all edge events", 32'(d), 32'hFEB);
        rd(A_CLR_ALL, '0, d);  check("R7", "global clear value", 32'(d), 0);
        rd(A_RAW, '0, d);      check("R7", "raw after global", 32'(d), 0);
        check("R12", "irq after clear", 32'(irq), 0);
    endtask

    task automatic t_level();
        logic [RD_W-1:0] d;
        @(negedge clk); rx_full_lvl = 1'b1;
        rd(A_RAW, '0, d); check("R8", "rx full level", 32'(d), 32'h004);
        rd(A_CLR_BASE + EV_RX_FULL, '0, d);
        rd(A_CLR_ALL, '0, d);
        rd(A_RAW, '0, d); check("R8", "level survives clears", 32'(d), 32'h004);
        check("R12", "irq from level", 32'(irq), 1);
        @(negedge clk); rx_full_lvl = 1'b0; tx_empty_lvl = 1'b1;
        rd(A_RAW, '0, d); check("R8", "tx empty level", 32'(d), 32'h010);
        @(negedge clk); tx_empty_lvl = 1'b0;
        rd(A_RAW, '0, d); check("R8", "levels low", 32'(d), 0);
    endtask

    task automatic t_collision();
        logic [RD_W-1:0] d;
        pulse(12'h200, '0);
        rd(A_CLR_BASE + 9, 12'h200, d); check("R9", "clear read sees bit", 32'(d), 1);
        rd(A_RAW, '0, d); check("R9", "event wins clear", 32'(d), 32'h200);
        rd(A_CLR_BASE + 9, 12'h001, d);
        rd(A_RAW, '0, d); check("R9", "other event, bit9 cleared", 32'(d), 32'h001);
        rd(A_CLR_ALL, 12'h001, d);
        rd(A_RAW, '0, d); check("R9", "event wins global clear", 32'(d), 32'h001);
        rd(A_CLR_ALL, '0, d);
    endtask

    task automatic t_mask();
        logic [RD_W-1:0] d;
        wr(A_MASK, '0);
        pulse(12'h800, '0);
        @(negedge clk);
        check("R12", "irq masked off", 32'(irq), 0);
        rd(A_MASKED, '0, d); check("R4", "masked status zero", 32'(d), 0);
        wr(A_MASK, 12'h800);
        @(negedge clk);
        check("R12", "irq after unmask", 32'(irq), 1);
        wr(A_MASKED, 12'hFFF);
        wr(A_RAW, 12'hFFF);
        rd(A_MASK, '0, d); check("R5", "writes elsewhere ignored", 32'(d), 32'h800);
        wr(A_MASK, DEFAULT_MASK);
        rd(A_CLR_ALL, '0, d);
    endtask

    task automatic t_abort();
        logic [RD_W-1:0] d;
        pulse(12'h040, 13'h1FFF);
        rd(A_ABRT, '0, d); check("R10", "reserved abort bits", 32'(d), 32'h1EBF);
        rd(A_CLR_ALL, '0, d);
        rd(A_ABRT, '0, d); check("R11", "global clear keeps abort", 32'(d), 32'h1EBF);
        rd(A_RAW, '0, d);  check("R7", "tx abort status cleared", 32'(d), 0);
        rd(A_CLR_BASE + EV_TX_ABRT, '0, d);
        rd(A_ABRT, '0, d); check("R11", "abort clear empties src", 32'(d), 0);
        pulse('0, 13'h0001);
        pulse('0, 13'h1000);
        rd(A_ABRT, '0, d); check("R10", "abort causes accumulate", 32'(d), 32'h1001);
        rd(A_CLR_BASE + EV_TX_ABRT, '0, d);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_global();
        t_level();
        t_collision();
        t_mask();
        t_abort();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule